// File: doc/BRIEF.md
# Block Move Instruction Executor

This block carries out one block-move instruction inside the DMA engine of a SCSI I/O processor. A pulse on `start` hands it the two instruction dwords. It decodes them into a target bus phase, an addressing mode, a byte count and a start address. When the mode asks for it, the block first reads the real address, or a count and address pair, through a simple read port. It then checks or drives the bus phase. Finally it moves the data as a series of small memory requests.

While the transfer runs, the block keeps a remaining-count register and a next-address register up to date. Both are visible on its ports. When the count reaches zero, a one-cycle `fetch_next` strobe tells the sequencer to fetch the next instruction. If the phase check fails in initiator mode, a one-cycle `phase_mismatch` strobe is raised instead and no data moves.

Top module: `bmove_exec`

## Requirements
- R1: In direct mode (instruction bits 29 and 28 clear), the byte count is taken from bits 23..0 of the first dword and the start address from the second dword. Data requests begin at that address.
- R2: Each data request carries a length of 1 to 4 bytes, never crosses a 4-byte address boundary, and is the largest length allowed by both the boundary and the remaining count.
- R3: Each accepted data request lowers `remain_cnt` by its length and raises `next_addr` by the same amount. At completion `remain_cnt` is 0 and `next_addr` equals the start address plus the count.
- R4: With bit 29 set and bit 28 clear (indirect), one word is read at the second-dword address, and the word read becomes the data start address.
- R5: With bit 28 set (table indirect, which takes priority over bit 29), two words are read at `dsa_base` plus the second dword and at that location plus 4. The low 24 bits of the first word are the count, the second word is the address, and the instruction's own count field has no effect.
- R6: In initiator mode (`target_mode`=0), if bits 26..24 differ from `bus_phase_in`, the block pulses `phase_mismatch` for one cycle, issues no data request and does not pulse `fetch_next`.
- R7: In target mode, no phase comparison is made. While busy, `phase_drive` is high and `phase_out` carries bits 26..24.
- R8: A count of zero completes with a `fetch_next` pulse and no data request.
- R9: `busy` rises the cycle after `start` is taken and falls in the cycle the completion or mismatch strobe is high. A `start` pulse while busy is ignored.
- R10: `fetch_next` is a single-cycle pulse raised in the cycle after the last data request is accepted, and it is never high together with `phase_mismatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin executing the presented instruction |
| instr0 | input | 32 | First instruction dword (mode, phase, count) |
| instr1 | input | 32 | Second instruction dword (address, pointer or offset) |
| dsa_base | input | 32 | Base register for table-indirect lookups |
| target_mode | input | 1 | 1 = target (drive phase), 0 = initiator (compare phase) |
| bus_phase_in | input | 3 | Latched bus phase for initiator comparison |
| phase_out | output | 3 | Phase field of the current instruction |
| phase_drive | output | 1 | Drive `phase_out` onto the bus (target mode, busy) |
| mem_rd_req | output | 1 | Pointer or table word read request |
| mem_rd_addr | output | 32 | Address of the word read |
| mem_rd_ack | input | 1 | Read data valid, request accepted |
| mem_rd_data | input | 32 | Word returned by the read |
| xfer_req | output | 1 | Data chunk request |
| xfer_addr | output | 32 | Chunk start address |
| xfer_len | output | 3 | Chunk length in bytes |
| xfer_ack | input | 1 | Chunk accepted |
| remain_cnt | output | 24 | Remaining byte count |
| next_addr | output | 32 | Next data address |
| busy | output | 1 | Instruction in progress |
| fetch_next | output | 1 | Transfer complete, fetch next instruction |
| phase_mismatch | output | 1 | Phase mismatch interrupt strobe |

## Verification
On every cycle, the assertions check the following:
- the chunk length and boundary rule;
- the step of the count and address registers on each accepted chunk;
- the pulse shape and exclusivity of the two strobes;
- that no request appears while idle;
- that the phase is driven only while busy;
- that the last accepted chunk is followed by `fetch_next`.

Only the bench scenarios can show the rest. These are:
- that addresses and counts come from the correct source in each addressing mode;
- that table and pointer reads hit the right locations;
- that the instruction count is ignored in table mode;
- that a mismatch suppresses all data movement;
- that a second `start` during a run has no effect.

// File: rtl/bmove_exec.sv
module bmove_exec #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int LANE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       instr0,
  input  logic [ADDR_W-1:0] instr1,
  input  logic [ADDR_W-1:0] dsa_base,
  input  logic              target_mode,
  input  logic [2:0]        bus_phase_in,
  output logic [2:0]        phase_out,
  output logic              phase_drive,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [31:0]       mem_rd_data,
  output logic              xfer_req,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [$clog2(LANE_BYTES):0] xfer_len,
  input  logic              xfer_ack,
  output logic [CNT_W-1:0]  remain_cnt,
  output logic [ADDR_W-1:0] next_addr,
  output logic              busy,
  output logic              fetch_next,
  output logic              phase_mismatch
);
  localparam int OFS_W = $clog2(LANE_BYTES);
  localparam int LEN_W = OFS_W + 1;
  localparam logic [LEN_W-1:0] LANE_L = LEN_W'(LANE_BYTES);
  localparam int BIT_TAB = 28;
  localparam int BIT_IND = 29;

  typedef enum logic [2:0] {S_IDLE, S_PTR, S_TCNT, S_TADR, S_CHK, S_MOVE} st_t;

  st_t              st;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic [2:0]        phase_q;
  logic [LEN_W-1:0]  room, len;

  assign room = LANE_L - LEN_W'(addr_q[OFS_W-1:0]);
  assign len  = (cnt_q < CNT_W'(room)) ? cnt_q[LEN_W-1:0] : room;

  assign busy        = (st != S_IDLE);
  assign mem_rd_req  = (st == S_PTR) || (st == S_TCNT) || (st == S_TADR);
  assign mem_rd_addr = ptr_q;
  assign xfer_req    = (st == S_MOVE);
  assign xfer_addr   = addr_q;
  assign xfer_len    = len;
  assign remain_cnt  = cnt_q;
  assign next_addr   = addr_q;
  assign phase_out   = phase_q;
  assign phase_drive = busy && target_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      cnt_q          <= '0;
      addr_q         <= '0;
      ptr_q          <= '0;
      phase_q        <= '0;
      fetch_next     <= 1'b0;
      phase_mismatch <= 1'b0;
    end else begin
      fetch_next     <= 1'b0;
      phase_mismatch <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          phase_q <= instr0[26:24];
          cnt_q   <= instr0[CNT_W-1:0];
          addr_q  <= instr1;
          if (instr0[BIT_TAB]) begin
            ptr_q <= dsa_base + instr1;
            st    <= S_TCNT;
          end else if (instr0[BIT_IND]) begin
            ptr_q <= instr1;
            st    <= S_PTR;
          end else begin
            st    <= S_CHK;
          end
        end
        S_PTR: if (mem_rd_ack) begin
          addr_q <= mem_rd_data[ADDR_W-1:0];
          st     <= S_CHK;
        end
        S_TCNT: if (mem_rd_ack) begin
          cnt_q <= mem_rd_data[CNT_W-1:0];
          ptr_q <= ptr_q + ADDR_W'(4);
          st    <= S_TADR;
        end
        S_TADR: if (mem_rd_ack) begin
          addr_q <= mem_rd_data[ADDR_W-1:0];
          st     <= S_CHK;
        end
        S_CHK: begin
          if (!target_mode && (bus_phase_in != phase_q)) begin
            phase_mismatch <= 1'b1;
            st             <= S_IDLE;
          end else if (cnt_q == '0) begin
            fetch_next <= 1'b1;
            st         <= S_IDLE;
          end else begin
            st <= S_MOVE;
          end
        end
        S_MOVE: if (xfer_ack) begin
          cnt_q  <= cnt_q - CNT_W'(len);
          addr_q <= addr_q + ADDR_W'(len);
          if (cnt_q == CNT_W'(len)) begin
            fetch_next <= 1'b1;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bmove_exec_chk.sv
module bmove_exec_chk #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int LANE_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_req,
  input logic              xfer_ack,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [$clog2(LANE_BYTES):0] xfer_len,
  input logic [CNT_W-1:0]  remain_cnt,
  input logic [ADDR_W-1:0] next_addr,
  input logic              mem_rd_req,
  input logic              busy,
  input logic              phase_drive,
  input logic              fetch_next,
  input logic              phase_mismatch
);
  localparam int OFS_W = $clog2(LANE_BYTES);
  localparam int LEN_W = OFS_W + 1;

  p_chunk_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_len != '0) && (xfer_len <= LEN_W'(LANE_BYTES)) &&
                 ((LEN_W'(xfer_addr[OFS_W-1:0]) + xfer_len) <= LEN_W'(LANE_BYTES)));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack) |=> remain_cnt == $past(remain_cnt) - CNT_W'($past(xfer_len)));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack) |=> next_addr == $past(next_addr) + ADDR_W'($past(xfer_len)));

  p_last_chunk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && (CNT_W'(xfer_len) == remain_cnt)) |=> fetch_next);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_next |=> !fetch_next);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_next && phase_mismatch));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!xfer_req && !mem_rd_req));

  p_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_next || phase_mismatch) |-> !busy);

  p_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_drive |-> busy);
endmodule

bind bmove_exec bmove_exec_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANE_BYTES(LANE_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .xfer_addr(xfer_addr), .xfer_len(xfer_len), .remain_cnt(remain_cnt),
  .next_addr(next_addr), .mem_rd_req(mem_rd_req), .busy(busy),
  .phase_drive(phase_drive), .fetch_next(fetch_next), .phase_mismatch(phase_mismatch));

// File: tb/bmove_exec_tb_top.sv
module bmove_exec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr0 = '0, instr1 = '0, dsa_base = '0;
  logic        target_mode = 1'b0;
  logic [2:0]  bus_phase_in = '0;
  logic [2:0]  phase_out;
  logic        phase_drive, mem_rd_req, mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        xfer_req, xfer_ack = 1'b0;
  logic [31:0] xfer_addr, next_addr;
  logic [2:0]  xfer_len;
  logic [23:0] remain_cnt;
  logic        busy, fetch_next, phase_mismatch;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmove_exec dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr0(instr0), .instr1(instr1),
    .dsa_base(dsa_base), .target_mode(target_mode), .bus_phase_in(bus_phase_in),
    .phase_out(phase_out), .phase_drive(phase_drive), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_ack(xfer_ack), .remain_cnt(remain_cnt), .next_addr(next_addr),
    .busy(busy), .fetch_next(fetch_next), .phase_mismatch(phase_mismatch));

  int checks = 0, errors = 0;
  logic [34:0] chunk_q[$];
  logic [31:0] rd_q[$];
  logic [31:0] memmod[logic [31:0]];
  int fn_cnt = 0, mm_cnt = 0;
  logic stall = 1'b0;
  logic [2:0] exp_phase = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    stall <= ~stall;
    if (fetch_next) fn_cnt++;
    if (phase_mismatch) mm_cnt++;
    if (busy && target_mode) begin
      check(phase_drive === 1'b1, "R7", "phase_drive", {31'd0, phase_drive}, 32'd1);
      check(phase_out === exp_phase, "R7", "phase_out", {29'd0, phase_out}, {29'd0, exp_phase});
    end
    if (mem_rd_req) begin
      if (rd_q.size() == 0) begin
        check(1'b0, "R4/R5", "unexpected read", mem_rd_addr, 32'd0);
        mem_rd_ack <= 1'b1;
        mem_rd_data <= 32'd0;
      end else begin
        logic [31:0] ea;
        ea = rd_q.pop_front();
        check(mem_rd_addr === ea, "R4/R5", "read addr", mem_rd_addr, ea);
        mem_rd_ack <= 1'b1;
        mem_rd_data <= memmod.exists(mem_rd_addr) ? memmod[mem_rd_addr] : 32'hDEAD_BEEF;
      end
    end else mem_rd_ack <= 1'b0;
    if (xfer_req && !stall) begin
      if (chunk_q.size() == 0) begin
        check(1'b0, "R2", "unexpected chunk", xfer_addr, {29'd0, xfer_len});
      end else begin
        logic [34:0] ec;
        ec = chunk_q.pop_front();
        check(xfer_addr === ec[34:3], "R1", "chunk addr", xfer_addr, ec[34:3]);
        check(xfer_len === ec[2:0], "R2", "chunk len", {29'd0, xfer_len}, {29'd0, ec[2:0]});
      end
      xfer_ack <= 1'b1;
    end else xfer_ack <= 1'b0;
  end

  function automatic logic [31:0] mk(input bit ind, input bit tab,
                                     input logic [2:0] ph, input logic [23:0] c);
    return {2'b00, ind, tab, 1'b0, ph, c};
  endfunction

  task automatic run(input string req, input logic [31:0] i0, input logic [31:0] i1,
                     input logic [31:0] eaddr, input logic [23:0] ecnt,
                     input bit emm, input bit poke);
    logic [31:0] a;
    logic [23:0] c;
    a = eaddr; c = ecnt;
    if (!emm)
      while (c != 0) begin
        logic [2:0] l;
        l = 3'(4 - a[1:0]);
        if (24'(l) > c) l = c[2:0];
        chunk_q.push_back({a, l});
        a = a + 32'(l);
        c = c - 24'(l);
      end
    fn_cnt = 0; mm_cnt = 0;
    exp_phase = i0[26:24];
    @(negedge clk);
    instr0 = i0; instr1 = i1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", "busy after start", {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (2) @(negedge clk);
      instr0 = mk(0, 0, 3'd0, 24'd7); instr1 = 32'h9000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    @(negedge clk);
    check(busy === 1'b0, "R9", {req, " busy cleared"}, {31'd0, busy}, 32'd0);
    check(fn_cnt == (emm ? 0 : 1), emm ? "R6" : "R10", {req, " fetch_next pulses"}, fn_cnt, emm ? 0 : 1);
    check(mm_cnt == (emm ? 1 : 0), "R6", {req, " mismatch pulses"}, mm_cnt, emm ? 1 : 0);
    check(chunk_q.size() == 0, "R3", {req, " chunks left"}, chunk_q.size(), 0);
    check(rd_q.size() == 0, "R5", {req, " reads left"}, rd_q.size(), 0);
    if (!emm) begin
      check(remain_cnt === 24'd0, "R3", {req, " final count"}, {8'd0, remain_cnt}, 0);
      check(next_addr === eaddr + {8'd0, ecnt}, "R3", {req, " final addr"}, next_addr, eaddr + {8'd0, ecnt});
    end
    chunk_q.delete(); rd_q.delete();
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && xfer_req === 1'b0 && mem_rd_req === 1'b0 && fetch_next === 1'b0,
          "R9", "reset idle", {28'd0, busy, xfer_req, mem_rd_req, fetch_next}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R3 R10 direct aligned
    run("R1", mk(0, 0, 3'd0, 24'd10), 32'h1000, 32'h1000, 24'd10, 0, 0);
    // R2 unaligned start
    run("R2", mk(0, 0, 3'd0, 24'd9), 32'h2003, 32'h2003, 24'd9, 0, 0);
    run("R2", mk(0, 0, 3'd0, 24'd3), 32'h0005, 32'h0005, 24'd3, 0, 0);
    run("R2", mk(0, 0, 3'd0, 24'd2), 32'h0007, 32'h0007, 24'd2, 0, 0);
    // R8 zero count
    run("R8", mk(0, 0, 3'd0, 24'd0), 32'h3000, 32'h3000, 24'd0, 0, 0);
    // R4 indirect
    memmod[32'h300] = 32'h4001;
    rd_q.push_back(32'h300);
    run("R4", mk(1, 0, 3'd0, 24'd6), 32'h300, 32'h4001, 24'd6, 0, 0);
    // R5 table indirect, instruction count ignored
    dsa_base = 32'h8000;
    memmod[32'h8010] = 32'hFF00_0005;
    memmod[32'h8014] = 32'h6002;
    rd_q.push_back(32'h8010); rd_q.push_back(32'h8014);
    run("R5", mk(0, 1, 3'd0, 24'd99), 32'h10, 32'h6002, 24'd5, 0, 0);
    // R5 table has priority over indirect
    rd_q.push_back(32'h8010); rd_q.push_back(32'h8014);
    run("R5", mk(1, 1, 3'd0, 24'd40), 32'h10, 32'h6002, 24'd5, 0, 0);
    // R6 initiator mismatch
    bus_phase_in = 3'd1;
    run("R6", mk(0, 0, 3'd3, 24'd8), 32'h5000, 32'h5000, 24'd8, 1, 0);
    // R6 initiator match with nonzero phase
    bus_phase_in = 3'd7;
    run("R6", mk(0, 0, 3'd7, 24'd4), 32'h5100, 32'h5100, 24'd4, 0, 0);
    // R7 target mode drives phase, no comparison
    target_mode = 1'b1; bus_phase_in = 3'd0;
    run("R7", mk(0, 0, 3'd6, 24'd7), 32'h7001, 32'h7001, 24'd7, 0, 0);
    target_mode = 1'b0;
    // R9 start while busy ignored
    run("R9", mk(0, 0, 3'd0, 24'd16), 32'hA000, 32'hA000, 24'd16, 0, 1);
    finish_run();
  end
endmodule